// File: doc/BRIEF.md
# Dual-Channel Converter Serial Output Engine

This block is the digital output side of a two-channel, simultaneous-sampling converter with 12-bit results. A host lowers the conversion-start strobe to enter hold; at that moment both parallel sample words are captured. The host then toggles the serial clock. Each active output line sends three leading zeros, then the result MSB first, then low. Each line has an enable that models whether the pin is actively driven or in high impedance.

With the mode select low (dual mode), each line carries its own channel in a 16-pulse frame. With the mode select high (single mode), only line 1 is used. It carries channel 1 and then channel 2 back to back in a 28-pulse frame.

The rising edge of the strobe sets what happens after the frame ends. If the strobe rises inside the continuous window, the lines stay driven low and wait for the next start. Otherwise the lines are released to high impedance at the next rising edge of either the strobe or the serial clock, so other devices can use the bus.

The serial clock and the strobe are sampled on the system clock. Every output change appears one system clock after the clock edge that first samples the level change.

Top module: `adc_sdo_engine`

## Requirements
- R1: After reset both enables and both data lines are 0.
- R2: A falling edge of `cnv_start` (hold entry) makes `sdo1_en` 1 on the next clock. It also makes `sdo2_en` equal to NOT `single_mode`, and holds both data lines at 0. The mode and both sample words are latched at that edge.
- R3: In dual mode, data stays 0 after serial clock rising edges 1 to 3. After rising edge k (4..15), `sdo1` carries bit 15-k of the channel-1 word and `sdo2` carries bit 15-k of the channel-2 word. Data is unchanged by falling edges.
- R4: In dual mode, both data lines are 0 after the 16th rising edge.
- R5: In single mode, `sdo1` is 0 after rising edges 1 to 3. It carries channel-1 bit 15-k after rising edge k (4..15), channel-2 bit 27-k after rising edge k (16..27), and 0 after rising edge 28. `sdo2_en` stays 0 for the whole frame.
- R6: Suppose the strobe rises when the rising-edge count is at least 14, counting a rise sampled in the same clock. Suppose also that, in dual mode, the falling-edge count is below 16, or in single mode the rising-edge count is below 28, counting same-clock edges. Then at the final falling edge (the 16th in dual mode, the 28th in single mode) the enables stay 1 with data 0. They remain so through further serial clock edges until the next hold entry.
- R7: Otherwise the enables stay 1 with data 0 after the final falling edge. Both enables drop to 0 on the next rising edge of the serial clock or of the strobe.
- R8: Changes on `ch1_word` or `ch2_word` after hold entry have no effect on the bits sent in that frame.
- R9: A strobe rise after fewer than 14 rising edges does not make the frame continuous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_start | input | 1 | Conversion-start strobe; a falling edge enters hold |
| sclk | input | 1 | Serial clock from the host, sampled on clk |
| single_mode | input | 1 | 1 = both results on line 1, 0 = one result per line |
| ch1_word | input | 12 | Channel-1 sample word |
| ch2_word | input | 12 | Channel-2 sample word |
| sdo1 | output | 1 | Serial data line 1 |
| sdo1_en | output | 1 | Line 1 driven (0 = high impedance) |
| sdo2 | output | 1 | Serial data line 2 |
| sdo2_en | output | 1 | Line 2 driven (0 = high impedance) |

## Verification
A strobe rise and a serial clock edge can be sampled in the same clock. When that happens, the counter update and the window test meet in one cycle. The bench provokes this by changing both inputs at the same falling clock edge, at the 14th rise, at the 16th fall in dual mode and at the 28th rise in single mode, and also at random positions. It judges the outcome by whether the enables survive past the final edge or drop on the next rising edge, comparing against a model that counts the coincident edge as already taken.

// File: rtl/adc_sdo_pkg.sv
package adc_sdo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_LINGER = 2'd2,
        ST_PEND   = 2'd3
    } frame_st_e;

    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic strb_rise;
        logic strb_fall;
    } edges_t;

endpackage

// File: rtl/sdo_edge_det.sv
module sdo_edge_det
    import adc_sdo_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sclk,
    input  logic   cnv_start,
    output edges_t edges
);

    typedef struct packed {
        logic sclk;
        logic strb;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d.sclk        = sclk;
        s_d.strb        = cnv_start;
        edges.sclk_rise = sclk & ~s_q.sclk;
        edges.sclk_fall = ~sclk & s_q.sclk;
        edges.strb_rise = cnv_start & ~s_q.strb;
        edges.strb_fall = ~cnv_start & s_q.strb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sclk <= 1'b0;
            s_q.strb <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/sdo_frame_ctl.sv
module sdo_frame_ctl
    import adc_sdo_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int LEAD   = 3,
    localparam int SGL_LEN = LEAD + 2 * DATA_W + 1,
    localparam int CW      = $clog2(SGL_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  edges_t        edges,
    input  logic          single_mode,
    output frame_st_e     st_q,
    output logic          single_q,
    output logic [CW-1:0] rise_cnt_q,
    output logic [CW-1:0] rise_cnt_d,
    output logic          shift_step,
    output logic          load
);

    localparam int DUAL_LEN = LEAD + DATA_W + 1;
    localparam int WIN_OPEN = LEAD + DATA_W - 1;
    localparam logic [CW-1:0] DUAL_C = CW'(DUAL_LEN);
    localparam logic [CW-1:0] SGL_C  = CW'(SGL_LEN);
    localparam logic [CW-1:0] WIN_C  = CW'(WIN_OPEN);

    typedef struct packed {
        frame_st_e     st;
        logic          single;
        logic          cont;
        logic [CW-1:0] rises;
        logic [CW-1:0] falls;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [CW-1:0] rises_n, falls_n, end_len;
    logic          in_win, cont_n;

    always_comb begin
        c_d     = c_q;
        end_len = c_q.single ? SGL_C : DUAL_C;
        rises_n = c_q.rises;
        falls_n = c_q.falls;
        if (edges.sclk_rise && c_q.rises != SGL_C) rises_n = c_q.rises + 1'b1;
        if (edges.sclk_fall && c_q.falls != SGL_C) falls_n = c_q.falls + 1'b1;
        in_win = (rises_n >= WIN_C) &&
                 (c_q.single ? (rises_n < SGL_C) : (falls_n < DUAL_C));
        cont_n = c_q.cont | (edges.strb_rise & in_win);

        if (edges.strb_fall) begin
            c_d.st     = ST_SHIFT;
            c_d.single = single_mode;
            c_d.cont   = 1'b0;
            c_d.rises  = '0;
            c_d.falls  = '0;
        end else begin
            case (c_q.st)
                ST_SHIFT: begin
                    c_d.rises = rises_n;
                    c_d.falls = falls_n;
                    c_d.cont  = cont_n;
                    if (edges.sclk_fall && falls_n == end_len)
                        c_d.st = cont_n ? ST_LINGER : ST_PEND;
                end
                ST_PEND: begin
                    if (edges.sclk_rise || edges.strb_rise) c_d.st = ST_IDLE;
                end
                default: ;
            endcase
        end

        st_q       = c_q.st;
        single_q   = c_q.single;
        rise_cnt_q = c_q.rises;
        rise_cnt_d = rises_n;
        load       = edges.strb_fall;
        shift_step = (c_q.st == ST_SHIFT) && edges.sclk_rise && !edges.strb_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, single: 1'b0, cont: 1'b0, rises: '0, falls: '0};
        end else begin
            c_q <= c_d;
        end
    end

    // R6: a continuous frame keeps its lines until the next hold entry
    a_r6_linger_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_LINGER && !edges.strb_fall) |=> (c_q.st == ST_LINGER));

    // R2: hold entry restarts the edge count
    a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        edges.strb_fall |=> (c_q.rises == '0 && c_q.st == ST_SHIFT));

endmodule

// File: rtl/sdo_shifter.sv
module sdo_shifter #(
    parameter int DATA_W = 12,
    parameter int LEAD   = 3,
    localparam int SGL_LEN = LEAD + 2 * DATA_W + 1,
    localparam int CW      = $clog2(SGL_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              single_q,
    input  logic [CW-1:0]     rise_idx,
    input  logic [DATA_W-1:0] ch1_word,
    input  logic [DATA_W-1:0] ch2_word,
    output logic              bit1,
    output logic              bit2
);

    typedef struct packed {
        logic [2*DATA_W-1:0] sr1;
        logic [DATA_W-1:0]   sr2;
        logic                b1;
        logic                b2;
    } shf_t;

    shf_t s_d, s_q;
    int   idx, span1;
    logic in1, in2;

    always_comb begin
        s_d   = s_q;
        idx   = int'(rise_idx);
        span1 = single_q ? 2 * DATA_W : DATA_W;
        in1   = (idx > LEAD) && (idx <= LEAD + span1);
        in2   = !single_q && (idx > LEAD) && (idx <= LEAD + DATA_W);
        if (load) begin
            s_d.sr1 = {ch1_word, ch2_word};
            s_d.sr2 = ch2_word;
            s_d.b1  = 1'b0;
            s_d.b2  = 1'b0;
        end else if (step) begin
            if (in1) begin
                s_d.b1  = s_q.sr1[2*DATA_W-1];
                s_d.sr1 = {s_q.sr1[2*DATA_W-2:0], 1'b0};
            end else begin
                s_d.b1 = 1'b0;
            end
            if (in2) begin
                s_d.b2  = s_q.sr2[DATA_W-1];
                s_d.sr2 = {s_q.sr2[DATA_W-2:0], 1'b0};
            end else begin
                s_d.b2 = 1'b0;
            end
        end
        bit1 = s_q.b1;
        bit2 = s_q.b2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R4: past the last data pulse of a dual frame no bit is sent
    a_r4_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !single_q && idx > LEAD + DATA_W) |=> (!s_q.b1 && !s_q.b2));

endmodule

// File: rtl/adc_sdo_engine.sv
module adc_sdo_engine
    import adc_sdo_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int LEAD   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_start,
    input  logic              sclk,
    input  logic              single_mode,
    input  logic [DATA_W-1:0] ch1_word,
    input  logic [DATA_W-1:0] ch2_word,
    output logic              sdo1,
    output logic              sdo1_en,
    output logic              sdo2,
    output logic              sdo2_en
);

    localparam int SGL_LEN = LEAD + 2 * DATA_W + 1;
    localparam int CW      = $clog2(SGL_LEN + 1);

    edges_t        edges;
    frame_st_e     st_q;
    logic          single_q, shift_step, load, bit1, bit2;
    logic [CW-1:0] rise_cnt_q, rise_cnt_d;

    sdo_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cnv_start (cnv_start),
        .edges     (edges)
    );

    sdo_frame_ctl #(.DATA_W(DATA_W), .LEAD(LEAD)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .edges       (edges),
        .single_mode (single_mode),
        .st_q        (st_q),
        .single_q    (single_q),
        .rise_cnt_q  (rise_cnt_q),
        .rise_cnt_d  (rise_cnt_d),
        .shift_step  (shift_step),
        .load        (load)
    );

    sdo_shifter #(.DATA_W(DATA_W), .LEAD(LEAD)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (shift_step),
        .single_q (single_q),
        .rise_idx (rise_cnt_d),
        .ch1_word (ch1_word),
        .ch2_word (ch2_word),
        .bit1     (bit1),
        .bit2     (bit2)
    );

    always_comb begin
        sdo1_en = (st_q != ST_IDLE);
        sdo2_en = sdo1_en & ~single_q;
        sdo1    = sdo1_en & bit1;
        sdo2    = sdo2_en & bit2;
    end

    // R2: hold entry drives the line low on the next clock
    a_r2_hold_drives: assert property (@(posedge clk) disable iff (!rst_n)
        edges.strb_fall |=> (sdo1_en && !sdo1 && !sdo2));

    // R3: leading pulses carry zeros
    a_r3_lead_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHIFT && int'(rise_cnt_q) <= LEAD) |-> (!sdo1 && !sdo2));

    // R5: line 2 stays released in single mode
    a_r5_line2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        single_q |-> !sdo2_en);

    // R7: a release always follows a rising edge of the strobe or serial clock
    a_r7_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo1_en) |-> $past(edges.sclk_rise || edges.strb_rise));

endmodule

// File: tb/adc_sdo_engine_tb.sv
module adc_sdo_engine_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnv_start = 1'b1;
    logic sclk = 1'b0;
    logic single_mode = 1'b0;
    logic [11:0] ch1_word = '0;
    logic [11:0] ch2_word = '0;
    logic sdo1, sdo1_en, sdo2, sdo2_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    adc_sdo_engine u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnv_start   (cnv_start),
        .sclk        (sclk),
        .single_mode (single_mode),
        .ch1_word    (ch1_word),
        .ch2_word    (ch2_word),
        .sdo1        (sdo1),
        .sdo1_en     (sdo1_en),
        .sdo2        (sdo2),
        .sdo2_en     (sdo2_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit exp_bit(input bit sgl, input bit line2, input int r,
                                   input logic [11:0] w1, input logic [11:0] w2);
        if (line2) begin
            if (sgl || r < 4 || r > 15) return 1'b0;
            return w2[15 - r];
        end
        if (r >= 4 && r <= 15) return w1[15 - r];
        if (sgl && r >= 16 && r <= 27) return w2[27 - r];
        return 1'b0;
    endfunction

    // kind: 0 none, 1 after rise k, 2 after fall k, 3 with rise k, 4 with fall k
    function automatic bit exp_cont(input bit sgl, input int kind, input int k);
        int r, f;
        if (kind == 0) return 1'b0;
        r = k;
        f = (kind == 1 || kind == 3) ? k - 1 : k;
        return (r >= 14) && (sgl ? (r < 28) : (f < 16));
    endfunction

    task automatic check_lines(input bit sgl, input int r, input logic [11:0] w1,
                               input logic [11:0] w2, input string req);
        bit e1, e2;
        e1 = exp_bit(sgl, 1'b0, r, w1, w2);
        e2 = exp_bit(sgl, 1'b1, r, w1, w2);
        chk(sdo1 == e1, req, $sformatf("sdo1 pulse %0d", r), int'(sdo1), int'(e1));
        chk(sdo2 == e2, req, $sformatf("sdo2 pulse %0d", r), int'(sdo2), int'(e2));
        chk(sdo1_en == 1'b1, req, "sdo1_en in frame", int'(sdo1_en), 1);
        chk(sdo2_en == !sgl, "R5", "sdo2_en in frame", int'(sdo2_en), int'(!sgl));
    endtask

    task automatic run_frame(input bit sgl, input int kind, input int k, input bit rel_strb);
        int n;
        bit cont, strb_hi;
        logic [11:0] w1, w2;
        string rq;
        n    = sgl ? 28 : 16;
        cont = exp_cont(sgl, kind, k);
        w1   = 12'($urandom);
        w2   = 12'($urandom);
        strb_hi = 1'b0;
        rq   = sgl ? "R5" : "R3";
        @(negedge clk);
        single_mode = sgl;
        ch1_word = w1;
        ch2_word = w2;
        cnv_start = 1'b0;
        wait_n(2);
        chk(sdo1_en == 1'b1 && sdo1 == 1'b0, "R2", "hold entry line1", int'({sdo1_en, sdo1}), 2);
        chk(sdo2_en == !sgl && sdo2 == 1'b0, "R2", "hold entry line2", int'(sdo2_en), int'(!sgl));
        for (int r = 1; r <= n; r++) begin
            @(negedge clk);
            sclk = 1'b1;
            if (kind == 3 && k == r) begin cnv_start = 1'b1; strb_hi = 1'b1; end
            wait_n(2);
            check_lines(sgl, r, w1, w2, (r == n && !sgl) ? "R4" : rq);
            ch1_word = 12'($urandom);   // R8: inputs move mid-frame
            ch2_word = 12'($urandom);
            if (kind == 1 && k == r) begin cnv_start = 1'b1; strb_hi = 1'b1; end
            @(negedge clk);
            sclk = 1'b0;
            if (kind == 4 && k == r) begin cnv_start = 1'b1; strb_hi = 1'b1; end
            wait_n(2);
            if (r < n) check_lines(sgl, r, w1, w2, "R8");
            if (kind == 2 && k == r) begin
                cnv_start = 1'b1;
                strb_hi = 1'b1;
                wait_n(2);
            end
        end
        chk(sdo1_en == 1'b1 && sdo1 == 1'b0, cont ? "R6" : "R7", "after final edge",
            int'({sdo1_en, sdo1}), 2);
        if (cont) begin
            sclk = 1'b1;
            wait_n(3);
            sclk = 1'b0;
            wait_n(3);
            chk(sdo1_en == 1'b1 && sdo1 == 1'b0, (kind == 0) ? "R9" : "R6",
                "continuous line kept", int'({sdo1_en, sdo1}), 2);
            chk(sdo2_en == !sgl && sdo2 == 1'b0, "R6", "continuous line2 kept",
                int'(sdo2_en), int'(!sgl));
        end else begin
            if (!strb_hi && rel_strb) begin
                cnv_start = 1'b1;
                strb_hi = 1'b1;
                wait_n(2);
            end else begin
                sclk = 1'b1;
                wait_n(2);
                sclk = 1'b0;
            end
            chk(sdo1_en == 1'b0 && sdo2_en == 1'b0, (k > 0 && k < 14) ? "R9" : "R7",
                "released", int'({sdo1_en, sdo2_en}), 0);
            wait_n(2);
            if (!strb_hi) begin
                cnv_start = 1'b1;
                wait_n(2);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5D0C_1A7E));
        wait_n(3);
        chk(sdo1_en == 0 && sdo2_en == 0 && sdo1 == 0 && sdo2 == 0, "R1", "reset",
            int'({sdo1_en, sdo2_en, sdo1, sdo2}), 0);
        rst_n = 1'b1;
        wait_n(2);
        chk(sdo1_en == 0 && sdo2_en == 0, "R1", "after reset", int'({sdo1_en, sdo2_en}), 0);

        run_frame(1'b0, 0, 0, 1'b0);   // R7 release by serial clock
        run_frame(1'b0, 0, 0, 1'b1);   // R7 release by strobe
        run_frame(1'b0, 1, 14, 1'b0);  // R6 just inside
        run_frame(1'b0, 3, 14, 1'b0);  // R6 coincident with 14th rise
        run_frame(1'b0, 1, 13, 1'b0);  // R9 too early
        run_frame(1'b0, 4, 16, 1'b0);  // R7 coincident with 16th fall
        run_frame(1'b0, 1, 16, 1'b0);  // R6 between 16th rise and fall
        run_frame(1'b1, 0, 0, 1'b1);   // R5 single, release
        run_frame(1'b1, 2, 20, 1'b0);  // R6 single continuous
        run_frame(1'b1, 3, 28, 1'b0);  // R7 coincident with 28th rise
        run_frame(1'b1, 1, 28, 1'b0);  // R7 after 28th rise
        run_frame(1'b1, 2, 5, 1'b0);   // R9 single too early

        for (int i = 0; i < 40; i++) begin
            bit sgl;
            int kind, k;
            sgl  = 1'($urandom);
            kind = int'($urandom % 5);
            k    = 1 + int'($urandom % (sgl ? 28 : 16));
            if (kind == 2 && k == (sgl ? 28 : 16)) kind = 0;
            if (kind == 0) k = 0;
            run_frame(sgl, kind, k, 1'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule